// File: doc/BRIEF.md
# Page Permission Downgrade Sequencer

This block removes or narrows an accelerator's access rights to a single physical page, for example when a mapping is changed or torn down. A command carries a page number and the permission the page should have afterwards. The block first reads the page's present permission from the protection table. It then chooses one of two step orders. If the page is writable, the block invalidates the accelerator's TLB entry for the page, flushes the page's dirty lines from the accelerator cache, and only then writes the new permission. If the page is not writable, the block writes the new permission at once.

Each step uses its own request/acknowledge pair. A request stays high until its acknowledge arrives, and only one step is active at a time. The block reports that it is busy for the whole downgrade and ignores any new command during that time. When the page is safe, the block pulses done. While the downgrade runs, accelerator accesses to that page are stalled, so no write can reach the page between the flush and the permission update. The TLB, the accelerator cache, the protection table and the permission cache all sit outside the block.

Top module: `pgrev_seq`

## Requirements
- R1: After reset, busy, done, acc_stall and all four step requests (rd_req, inv_req, fl_req, wr_req) are low.
- R2: A command is accepted on a clock edge where cmd_valid is high and busy is low. On the next cycle busy is high and rd_req is high, with rd_page equal to the accepted cmd_page.
- R3: A cmd_valid that arrives while busy is high has no effect. The page and permission in flight stay unchanged, the second page's table entry is not written, and only one done pulse follows.
- R4: A permission is 2 bits. Bit 1 is write access, bit 0 is read access, and 00 means no access. If the permission read back on the read handshake has bit 1 set, the next step is an invalidate (inv_req) for the same page.
- R5: For a writable page, the flush request (fl_req) starts on the cycle after the invalidate handshake. The table write (wr_req) starts only on the cycle after the flush handshake, so the full order is read, invalidate, flush, write.
- R6: If the permission read back has bit 1 clear (01 or 00), the next step is the table write. No invalidate or flush request is issued for that command.
- R7: At most one step request is high at any time. Each request stays high, with its page unchanged, until the cycle in which its acknowledge is seen.
- R8: wr_perm carries the new permission from the command. done is high for exactly one cycle, on the cycle after the write handshake. busy is low in that cycle.
- R9: acc_stall is high exactly when busy is high, acc_valid is high, and acc_page equals the page under downgrade.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Downgrade command strobe |
| cmd_page | input | PAGE_W | Physical page number of the command |
| cmd_perm | input | 2 | New permission (bit 1 write, bit 0 read) |
| busy | output | 1 | Downgrade in progress; commands are ignored |
| done | output | 1 | One-cycle pulse when the page is safe |
| rd_req | output | 1 | Protection table read request |
| rd_page | output | PAGE_W | Page to read |
| rd_ack | input | 1 | Read acknowledge |
| rd_perm | input | 2 | Current permission, valid with rd_ack |
| inv_req | output | 1 | Accelerator TLB invalidate request |
| inv_page | output | PAGE_W | Page to invalidate |
| inv_ack | input | 1 | Invalidate acknowledge |
| fl_req | output | 1 | Accelerator cache dirty-line flush request |
| fl_page | output | PAGE_W | Page to flush |
| fl_ack | input | 1 | Flush acknowledge |
| wr_req | output | 1 | Protection table and permission cache write request |
| wr_page | output | PAGE_W | Page to write |
| wr_perm | output | 2 | Permission to write |
| wr_ack | input | 1 | Write acknowledge |
| acc_valid | input | 1 | Accelerator access in flight |
| acc_page | input | PAGE_W | Page of the accelerator access |
| acc_stall | output | 1 | Hold the accelerator access |

## Verification
The bench covers each prior permission class: read-write, read-only, none, and write-only (10). A design that keyed the path on the read bit, or on the new permission, would skip the flush for the write-only page or flush a read-only page. Acknowledge latencies are varied, so a design that moved on without waiting, or dropped a request early, shows up in the per-cycle comparison. A second command is sent mid-downgrade, which catches a design that relatches the page or writes the wrong table entry. The stall output is probed on the target page and on a neighbouring page during the flush, and again after done. This catches a compare that leaks to other pages or stays set after completion.

// File: rtl/pgrev_pkg.sv
package pgrev_pkg;

    localparam int PERM_BITS = 2;
    localparam int PERM_WR   = 1;
    localparam int PERM_RD   = 0;

    typedef logic [PERM_BITS-1:0] perm_t;

    // Step encoding: value i+1 is the step served by channel i
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_INVAL = 3'd2,
        ST_FLUSH = 3'd3,
        ST_WRITE = 3'd4
    } step_e;

    localparam int N_STEP = 4;

    function automatic logic perm_writable(input perm_t p);
        return p[PERM_WR];
    endfunction

endpackage

// File: rtl/pgrev_ctrl.sv
module pgrev_ctrl
    import pgrev_pkg::*;
#(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [PAGE_W-1:0] cmd_page,
    input  perm_t             cmd_perm,
    input  logic              step_ack,
    input  perm_t             rd_perm,
    output step_e             step,
    output logic [PAGE_W-1:0] page,
    output perm_t             new_perm,
    output logic              done
);

    typedef struct packed {
        step_e             st;
        logic [PAGE_W-1:0] page;
        perm_t             new_perm;
        logic              done;
    } ctl_s;

    localparam ctl_s CTL_RST = '{st: ST_IDLE, page: '0, new_perm: '0, done: 1'b0};

    ctl_s ctl_d, ctl_q;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    ctl_d.st       = ST_READ;
                    ctl_d.page     = cmd_page;
                    ctl_d.new_perm = cmd_perm;
                end
            end
            ST_READ: begin
                if (step_ack) begin
                    ctl_d.st = perm_writable(rd_perm) ? ST_INVAL : ST_WRITE;
                end
            end
            ST_INVAL: begin
                if (step_ack) ctl_d.st = ST_FLUSH;
            end
            ST_FLUSH: begin
                if (step_ack) ctl_d.st = ST_WRITE;
            end
            ST_WRITE: begin
                if (step_ack) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.done = 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign step     = ctl_q.st;
    assign page     = ctl_q.page;
    assign new_perm = ctl_q.new_perm;
    assign done     = ctl_q.done;

endmodule

// File: rtl/pgrev_guard.sv
module pgrev_guard #(
    parameter int PAGE_W = 8
) (
    input  logic              active,
    input  logic [PAGE_W-1:0] held_page,
    input  logic              acc_valid,
    input  logic [PAGE_W-1:0] acc_page,
    output logic              acc_stall
);

    logic hit;

    always_comb begin
        hit       = (acc_page == held_page);
        acc_stall = active && acc_valid && hit;
    end

endmodule

// File: rtl/pgrev_seq.sv
module pgrev_seq
    import pgrev_pkg::*;
#(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [PAGE_W-1:0] cmd_page,
    input  logic [1:0]        cmd_perm,
    output logic              busy,
    output logic              done,
    output logic              rd_req,
    output logic [PAGE_W-1:0] rd_page,
    input  logic              rd_ack,
    input  logic [1:0]        rd_perm,
    output logic              inv_req,
    output logic [PAGE_W-1:0] inv_page,
    input  logic              inv_ack,
    output logic              fl_req,
    output logic [PAGE_W-1:0] fl_page,
    input  logic              fl_ack,
    output logic              wr_req,
    output logic [PAGE_W-1:0] wr_page,
    output logic [1:0]        wr_perm,
    input  logic              wr_ack,
    input  logic              acc_valid,
    input  logic [PAGE_W-1:0] acc_page,
    output logic              acc_stall
);

    step_e             step;
    logic [PAGE_W-1:0] page;
    perm_t             new_perm;
    logic              step_ack;
    logic              accept;
    logic [N_STEP-1:0] req_vec;
    logic [N_STEP-1:0] ack_vec;

    assign busy     = (step != ST_IDLE);
    assign accept   = cmd_valid && !busy;
    assign ack_vec  = {wr_ack, fl_ack, inv_ack, rd_ack};
    assign step_ack = |(req_vec & ack_vec);

    // One request line per step channel
    for (genvar i = 0; i < N_STEP; i++) begin : g_chan
        assign req_vec[i] = (step == step_e'(i + 1));
    end

    assign {wr_req, fl_req, inv_req, rd_req} = req_vec;
    assign rd_page  = page;
    assign inv_page = page;
    assign fl_page  = page;
    assign wr_page  = page;
    assign wr_perm  = new_perm;

    pgrev_ctrl #(.PAGE_W(PAGE_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (accept),
        .cmd_page  (cmd_page),
        .cmd_perm  (cmd_perm),
        .step_ack  (step_ack),
        .rd_perm   (rd_perm),
        .step      (step),
        .page      (page),
        .new_perm  (new_perm),
        .done      (done)
    );

    pgrev_guard #(.PAGE_W(PAGE_W)) u_guard (
        .active    (busy),
        .held_page (page),
        .acc_valid (acc_valid),
        .acc_page  (acc_page),
        .acc_stall (acc_stall)
    );

endmodule

// File: rtl/pgrev_chk.sv
module pgrev_chk #(
    parameter int PAGE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              rd_req,
    input logic              rd_ack,
    input logic [1:0]        rd_perm,
    input logic              inv_req,
    input logic              inv_ack,
    input logic              fl_req,
    input logic [PAGE_W-1:0] fl_page,
    input logic              fl_ack,
    input logic              wr_req,
    input logic [PAGE_W-1:0] wr_page,
    input logic              wr_ack,
    input logic              acc_valid,
    input logic [PAGE_W-1:0] acc_page,
    input logic              acc_stall
);

    // R7
    step_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_req, inv_req, fl_req, wr_req}));

    // R7
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ack |=> rd_req);

    // R7
    inv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_req && !inv_ack |=> inv_req);

    // R7
    fl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req && !fl_ack |=> fl_req);

    // R7
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && !wr_ack |=> wr_req);

    // R4
    rw_to_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && rd_ack && rd_perm[1] |=> inv_req);

    // R6
    ro_to_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && rd_ack && !rd_perm[1] |=> wr_req && !inv_req && !fl_req);

    // R5
    inval_to_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_req && inv_ack |=> fl_req);

    // R5
    flush_to_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req && fl_ack |=> wr_req);

    // R8
    write_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && wr_ack |=> done && !busy);

    // R3
    page_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(wr_page));

    // R9
    flush_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req && acc_valid && (acc_page == fl_page) |-> acc_stall);

    // R9
    idle_nostall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !acc_stall);

endmodule

bind pgrev_seq pgrev_chk #(.PAGE_W(PAGE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .rd_req    (rd_req),
    .rd_ack    (rd_ack),
    .rd_perm   (rd_perm),
    .inv_req   (inv_req),
    .inv_ack   (inv_ack),
    .fl_req    (fl_req),
    .fl_page   (fl_page),
    .fl_ack    (fl_ack),
    .wr_req    (wr_req),
    .wr_page   (wr_page),
    .wr_ack    (wr_ack),
    .acc_valid (acc_valid),
    .acc_page  (acc_page),
    .acc_stall (acc_stall)
);

// File: tb/sim_pgrev_seq.sv
module sim_pgrev_seq;

    localparam int CLK_NS = 10;
    localparam int PW     = 8;
    localparam int NPAGE  = 1 << PW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [PW-1:0] cmd_page = '0;
    logic [1:0]    cmd_perm = '0;
    logic          busy, done;
    logic          rd_req, inv_req, fl_req, wr_req;
    logic [PW-1:0] rd_page, inv_page, fl_page, wr_page;
    logic [1:0]    wr_perm;
    logic          rd_ack = 1'b0, inv_ack = 1'b0, fl_ack = 1'b0, wr_ack = 1'b0;
    logic [1:0]    rd_perm = '0;
    logic          acc_valid = 1'b0;
    logic [PW-1:0] acc_page = '0;
    logic          acc_stall;

    int errors = 0;
    int checks = 0;
    int done_cnt = 0;

    logic [1:0] tbl [NPAGE];
    int lat [4];
    int cnt [4];
    int ev_kind [$];
    int ev_page [$];

    // reference model state
    int         ms = 0;
    int         m_pg = 0;
    logic [1:0] m_np = '0;
    logic       m_done = 1'b0;

    always #(CLK_NS / 2) clk = ~clk;

    pgrev_seq #(.PAGE_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_page(cmd_page),
        .cmd_perm(cmd_perm), .busy(busy), .done(done),
        .rd_req(rd_req), .rd_page(rd_page), .rd_ack(rd_ack), .rd_perm(rd_perm),
        .inv_req(inv_req), .inv_page(inv_page), .inv_ack(inv_ack),
        .fl_req(fl_req), .fl_page(fl_page), .fl_ack(fl_ack),
        .wr_req(wr_req), .wr_page(wr_page), .wr_perm(wr_perm), .wr_ack(wr_ack),
        .acc_valid(acc_valid), .acc_page(acc_page), .acc_stall(acc_stall)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: advances on each edge from the bench-driven inputs only
    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; m_pg = 0; m_np = '0; m_done = 1'b0;
        end else begin
            m_done = 1'b0;
            case (ms)
                0: if (cmd_valid) begin ms = 1; m_pg = int'(cmd_page); m_np = cmd_perm; end
                1: if (rd_ack) ms = rd_perm[1] ? 2 : 4;
                2: if (inv_ack) ms = 3;
                3: if (fl_ack) ms = 4;
                4: if (wr_ack) begin ms = 0; m_done = 1'b1; end
                default: ms = 0;
            endcase
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(busy == (ms != 0), "R2 busy", int'(busy), int'(ms != 0));
            check(rd_req == (ms == 1), "R2 rd_req", int'(rd_req), int'(ms == 1));
            check(inv_req == (ms == 2), "R4 inv_req", int'(inv_req), int'(ms == 2));
            check(fl_req == (ms == 3), "R5 fl_req", int'(fl_req), int'(ms == 3));
            check(wr_req == (ms == 4), "R7 wr_req", int'(wr_req), int'(ms == 4));
            check(done == m_done, "R8 done", int'(done), int'(m_done));
            check(int'(wr_page) == m_pg && rd_page == wr_page && inv_page == wr_page
                  && fl_page == wr_page, "R3 page", int'(wr_page), m_pg);
            check(wr_perm == m_np, "R8 wr_perm", int'(wr_perm), int'(m_np));
            check(acc_stall == ((ms != 0) && acc_valid && int'(acc_page) == m_pg),
                  "R9 stall", int'(acc_stall),
                  int'((ms != 0) && acc_valid && int'(acc_page) == m_pg));
            if (done) done_cnt++;
        end
    end

    // Responders for the four step channels
    always @(posedge clk) begin
        logic       req [4];
        logic       ackv [4];
        logic [1:0] pw_save;
        #2;
        req[0] = rd_req; req[1] = inv_req; req[2] = fl_req; req[3] = wr_req;
        ackv[0] = rd_ack; ackv[1] = inv_ack; ackv[2] = fl_ack; ackv[3] = wr_ack;
        pw_save = wr_perm;
        for (int i = 0; i < 4; i++) begin
            if (ackv[i]) begin
                ackv[i] = 1'b0;
                ev_kind.push_back(i);
                ev_page.push_back(int'(wr_page));
                if (i == 3) tbl[wr_page] = pw_save;
            end else if (req[i] && rst_n) begin
                if (cnt[i] == 0) begin
                    ackv[i] = 1'b1;
                    cnt[i] = lat[i];
                    if (i == 0) rd_perm = tbl[rd_page];
                end else begin
                    cnt[i]--;
                end
            end
        end
        rd_ack = ackv[0]; inv_ack = ackv[1]; fl_ack = ackv[2]; wr_ack = ackv[3];
    end

    task automatic set_lat(input int l);
        for (int i = 0; i < 4; i++) begin lat[i] = l; cnt[i] = l; end
    endtask

    task automatic pulse_cmd(input int pg, input logic [1:0] pm);
        @(posedge clk); #2;
        cmd_valid = 1'b1; cmd_page = PW'(pg); cmd_perm = pm;
        @(posedge clk); #2;
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(input int start);
        for (int k = 0; k < 500 && done_cnt == start; k++) @(negedge clk);
        check(done_cnt == start + 1, "R8 done count", done_cnt, start + 1);
    endtask

    task automatic run_cmd(input int pg, input logic [1:0] pm, input string tag);
        logic [1:0] old;
        int         start;
        old = tbl[pg];
        start = done_cnt;
        ev_kind.delete(); ev_page.delete();
        pulse_cmd(pg, pm);
        wait_done(start);
        @(posedge clk); #3;
        if (old[1]) begin
            check(ev_kind.size() == 4, {tag, " R5 step count"}, ev_kind.size(), 4);
            for (int i = 0; i < 4 && i < ev_kind.size(); i++)
                check(ev_kind[i] == i, {tag, " R5 step order"}, ev_kind[i], i);
        end else begin
            check(ev_kind.size() == 2, {tag, " R6 step count"}, ev_kind.size(), 2);
            if (ev_kind.size() == 2)
                check(ev_kind[0] == 0 && ev_kind[1] == 3, {tag, " R6 read then write"},
                      ev_kind[1], 3);
        end
        for (int i = 0; i < ev_page.size(); i++)
            check(ev_page[i] == pg, {tag, " R4 page"}, ev_page[i], pg);
        check(tbl[pg] == pm, {tag, " R8 table"}, int'(tbl[pg]), int'(pm));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int start;
        for (int i = 0; i < NPAGE; i++) tbl[i] = 2'b00;
        tbl[5] = 2'b11; tbl[9] = 2'b01; tbl[12] = 2'b00; tbl[200] = 2'b10;
        tbl[7] = 2'b11; tbl[8] = 2'b11; tbl[40] = 2'b11;
        set_lat(0);
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(!busy && !done && !acc_stall && !rd_req && !inv_req && !fl_req && !wr_req,
              "R1 reset", int'({busy, done, rd_req, inv_req, fl_req, wr_req}), 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(posedge clk);

        run_cmd(5, 2'b01, "rw page");          // R4 R5
        run_cmd(9, 2'b00, "ro page");          // R6
        run_cmd(12, 2'b00, "none page");       // R6
        set_lat(3);
        run_cmd(200, 2'b00, "wo page slow");   // R4 R5 R7
        set_lat(1);
        run_cmd(5, 2'b00, "ro after rw");      // R6

        // R3: second command while busy is ignored
        set_lat(4);
        start = done_cnt;
        ev_kind.delete(); ev_page.delete();
        pulse_cmd(7, 2'b01);
        repeat (3) @(posedge clk);
        pulse_cmd(8, 2'b00);
        wait_done(start);
        repeat (10) @(negedge clk);
        check(done_cnt == start + 1, "R3 single done", done_cnt, start + 1);
        check(tbl[8] == 2'b11, "R3 other page untouched", int'(tbl[8]), 3);
        check(tbl[7] == 2'b01, "R3 first command applied", int'(tbl[7]), 1);
        check(ev_kind.size() == 4, "R3 step count", ev_kind.size(), 4);

        // R9: stall on the page under downgrade
        start = done_cnt;
        acc_valid = 1'b1; acc_page = 8'd40;
        pulse_cmd(40, 2'b01);
        for (int k = 0; k < 200 && !fl_req; k++) @(negedge clk);
        @(negedge clk);
        check(fl_req && acc_stall, "R9 stall during flush", int'(acc_stall), 1);
        @(posedge clk); #2; acc_page = 8'd41;
        @(negedge clk);
        check(!acc_stall, "R9 other page passes", int'(acc_stall), 0);
        @(posedge clk); #2; acc_page = 8'd40;
        wait_done(start);
        @(negedge clk);
        check(!acc_stall, "R9 released after done", int'(acc_stall), 0);
        acc_valid = 1'b0;

        // back-to-back with zero latency
        set_lat(0);
        run_cmd(40, 2'b00, "b2b ro");          // R6
        run_cmd(200, 2'b11, "b2b none");       // R6

        repeat (3) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule